// File: doc/BRIEF.md
# Indexed-Color Palette Store with 15-Bit Packed Entries

This block holds the color lookup table of an indexed-color display pipeline. Software sees 128 words of 32 bits each. Every word packs two 16-bit color entries, so the table holds 256 colors in total. A bus write stores the full 32-bit word as given, and a bus read returns that same word unchanged. The register bank decodes the palette address window and passes the block a select strobe and a word index.

The pixel side has its own lookup port. It takes an 8-bit pixel index and produces a 24-bit RGB color one clock later. Inside an entry, each color component is 5 bits wide. The block widens each component to 8 bits by appending three zero bits. The top bit of an entry carries an intensity flag, which the block ignores. A red/blue swap input exchanges the outer two bytes of the output color.

Bus writes and pixel lookups are independent and may happen in the same cycle. A lookup or a bus read that hits the word being written in that cycle sees the contents from before the write.

Top module: `clut_palette`

## Requirements
- R1: After reset, `bus_rvalid` and `rgb_valid` are low and every palette word reads as zero.
- R2: A bus read (`bus_sel` and `bus_rd` high) returns the raw 32-bit word at `bus_widx` on `bus_rdata` in the next cycle, with `bus_rvalid` high for exactly that cycle. The returned word is the value last written there, bit for bit.
- R3: A word is written only when `bus_sel` and `bus_we` are both high. With `bus_sel` low, `bus_we` has no effect, and a later read of the same word shows this.
- R4: Pixel index p selects word p>>1. An even p uses bits [15:0] of that word; an odd p uses bits [31:16].
- R5: Within a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 never changes the output color.
- R6: Each 5-bit component c appears as the 8-bit value c<<3, so the low three bits of every output byte are zero.
- R7: With `swap_rb` low, `rgb_out` is {red, green, blue} from bit 23 down to bit 0. With `swap_rb` high, it is {blue, green, red}. `swap_rb` is sampled in the same cycle as the index.
- R8: `rgb_valid` is high exactly one cycle after a cycle in which `pix_valid` is high, and low otherwise.
- R9: A lookup in the same cycle as a write to the word it reads returns the old entry. The next lookup returns the new entry.
- R10: A bus read in the same cycle as a write to the same word returns the old word. The next read returns the new word.
- R11: `rgb_out` holds its value through cycles with no lookup, and `bus_rdata` holds its value through cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Palette window selected by the register bank |
| bus_we | input | 1 | Write strobe, valid with `bus_sel` |
| bus_rd | input | 1 | Read strobe, valid with `bus_sel` |
| bus_widx | input | 7 | Word index inside the palette window |
| bus_wdata | input | 32 | Raw word to store |
| bus_rdata | output | 32 | Raw word returned for a read |
| bus_rvalid | output | 1 | `bus_rdata` carries a read result this cycle |
| pix_valid | input | 1 | Lookup request |
| pix_idx | input | 8 | Pixel color index |
| swap_rb | input | 1 | Exchange red and blue bytes at the output |
| rgb_valid | output | 1 | `rgb_out` carries a lookup result this cycle |
| rgb_out | output | 24 | Expanded 8:8:8 color |

## Verification
The hardest case to reach from the ports is a collision: a write and a lookup, or a write and a read, aimed at the same word in the same cycle. To hit it, the driver presents both requests on one edge. It computes the expected result from its shadow table before applying the write, then repeats the access on the next cycle to expect the new value. Bit-15 independence gets its own check: entries that differ only in the intensity bit must produce identical colors. Both halves of every word are looked up with both swap settings, so every entry exercises the half selection and the byte order.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned CLUT_WORDS       = 128;
  localparam int unsigned WORD_W           = 32;
  localparam int unsigned ENTRY_W          = 16;
  localparam int unsigned COMP_IN_W        = 5;
  localparam int unsigned COMP_OUT_W       = 8;
  localparam int unsigned ENTRIES_PER_WORD = WORD_W / ENTRY_W;
  localparam int unsigned WIDX_W           = $clog2(CLUT_WORDS);
  localparam int unsigned PIDX_W           = $clog2(CLUT_WORDS * ENTRIES_PER_WORD);
  localparam int unsigned RED_LSB          = 0;
  localparam int unsigned GRN_LSB          = RED_LSB + COMP_IN_W;
  localparam int unsigned BLU_LSB          = GRN_LSB + COMP_IN_W;
  localparam int unsigned RGB_W            = 3 * COMP_OUT_W;

  typedef struct packed {
    logic [COMP_OUT_W-1:0] hi;
    logic [COMP_OUT_W-1:0] mid;
    logic [COMP_OUT_W-1:0] lo;
  } rgb_t;

  // widen a component by appending zeros below it
  function automatic logic [COMP_OUT_W-1:0] widen(input logic [COMP_IN_W-1:0] c);
    widen = {c, {(COMP_OUT_W - COMP_IN_W){1'b0}}};
  endfunction

  // pick one packed entry out of a bus word
  function automatic logic [ENTRY_W-1:0] select_entry(input logic [WORD_W-1:0] w,
                                                      input logic upper);
    select_entry = upper ? w[WORD_W-1 -: ENTRY_W] : w[ENTRY_W-1:0];
  endfunction

  // unpack components, bit ENTRY_W-1 (intensity) is dropped here
  function automatic rgb_t decode_entry(input logic [ENTRY_W-1:0] e, input logic swap);
    rgb_t o;
    logic [COMP_OUT_W-1:0] r8, g8, b8;
    r8 = widen(e[RED_LSB +: COMP_IN_W]);
    g8 = widen(e[GRN_LSB +: COMP_IN_W]);
    b8 = widen(e[BLU_LSB +: COMP_IN_W]);
    o.mid = g8;
    o.hi  = swap ? b8 : r8;
    o.lo  = swap ? r8 : b8;
    decode_entry = o;
  endfunction
endpackage

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int unsigned N_WORDS = CLUT_WORDS,
  parameter int unsigned W       = WORD_W,
  localparam int unsigned AW     = $clog2(N_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] ra_idx,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_idx,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] words [N_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_idx] <= wr_data;
    end
  end

  // both read ports see pre-write contents in a colliding cycle
  assign ra_data = words[ra_idx];
  assign rb_data = words[rb_idx];
endmodule

// File: rtl/clut_bus_port.sv
module clut_bus_port
  import clut_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_fire,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_fire;
      if (rd_fire) rdata <= word_in;
    end
  end
endmodule

// File: rtl/clut_lookup.sv
module clut_lookup
  import clut_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned EW = ENTRY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          upper_half,
  input  logic          swap,
  input  logic [W-1:0]  word_in,
  output logic [EW-1:0] entry,
  output logic          out_valid,
  output rgb_t          out_rgb
);
  rgb_t rgb_next;

  always_comb begin
    entry    = select_entry(word_in, upper_half);
    rgb_next = decode_entry(entry, swap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= req;
      if (req) out_rgb <= rgb_next;
    end
  end
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_pkg::*;
#(
  parameter int unsigned N_WORDS = CLUT_WORDS,
  localparam int unsigned AW     = $clog2(N_WORDS),
  localparam int unsigned PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_widx,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              pix_valid,
  input  logic [PW-1:0]     pix_idx,
  input  logic              swap_rb,
  output logic              rgb_valid,
  output logic [RGB_W-1:0]  rgb_out
);
  // named internal events for the checker
  logic               wr_fire;
  logic               rd_fire;
  logic [WORD_W-1:0]  bus_word;
  logic [WORD_W-1:0]  pix_word;
  logic [ENTRY_W-1:0] lk_entry;
  rgb_t               lk_rgb;

  assign wr_fire = bus_sel & bus_we;
  assign rd_fire = bus_sel & bus_rd;

  clut_store #(.N_WORDS(N_WORDS), .W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_idx  (bus_widx),
    .wr_data (bus_wdata),
    .ra_idx  (bus_widx),
    .ra_data (bus_word),
    .rb_idx  (pix_idx[PW-1:1]),
    .rb_data (pix_word)
  );

  clut_bus_port #(.W(WORD_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .word_in (bus_word),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  clut_lookup #(.W(WORD_W), .EW(ENTRY_W)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (pix_valid),
    .upper_half (pix_idx[0]),
    .swap       (swap_rb),
    .word_in    (pix_word),
    .entry      (lk_entry),
    .out_valid  (rgb_valid),
    .out_rgb    (lk_rgb)
  );

  assign rgb_out = lk_rgb;
endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk
  import clut_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rd_fire,
  input logic               bus_rvalid,
  input logic [WORD_W-1:0]  bus_rdata,
  input logic               pix_valid,
  input logic               swap_rb,
  input logic [ENTRY_W-1:0] lk_entry,
  input logic               rgb_valid,
  input logic [RGB_W-1:0]   rgb_out
);
  AST_READ_GIVES_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_rvalid); // R2
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !bus_rvalid); // R2
  AST_LOOKUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> rgb_valid); // R8
  AST_NO_SPURIOUS_RGB: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !rgb_valid); // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid |-> (rgb_out[18:16] == 3'b0 && rgb_out[10:8] == 3'b0 && rgb_out[2:0] == 3'b0)); // R6
  AST_BLUE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !swap_rb) |=> rgb_out[7:3] == $past(lk_entry[14:10])); // R5
  AST_SWAPPED_RED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && swap_rb) |=> rgb_out[7:3] == $past(lk_entry[4:0])); // R7
  AST_RGB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(rgb_out)); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(bus_rdata)); // R11
endmodule

bind clut_palette clut_palette_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_fire    (rd_fire),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata),
  .pix_valid  (pix_valid),
  .swap_rb    (swap_rb),
  .lk_entry   (lk_entry),
  .rgb_valid  (rgb_valid),
  .rgb_out    (rgb_out)
);

// File: tb/clut_palette_test.sv
module clut_palette_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        swap_rb = 1'b0;
  logic        rgb_valid;
  logic [23:0] rgb_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] shadow [128];
  logic [23:0] q_rgb [$];
  string       t_rgb [$];
  logic [31:0] q_rd  [$];
  string       t_rd  [$];

  always #4 clk = ~clk;

  clut_palette uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_rd(bus_rd),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .swap_rb(swap_rb), .rgb_valid(rgb_valid), .rgb_out(rgb_out)
  );

  function automatic logic [23:0] model_rgb(input logic [7:0] p, input logic sw);
    logic [31:0] w;
    logic [15:0] e;
    logic [7:0] r, g, b;
    w = shadow[p >> 1];
    e = (p % 2 == 1) ? (w >> 16) : (w & 32'hFFFF);
    r = 8'((e & 16'h001F) * 8);
    g = 8'(((e >> 5) & 16'h001F) * 8);
    b = 8'(((e >> 10) & 16'h001F) * 8);
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  function automatic logic [31:0] pattern(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ (32'(i) << 7) ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expectations use pre-write shadow
  task automatic cyc(input bit sel, input bit we, input bit rd, input int widx,
                     input logic [31:0] wd, input bit pv, input int pidx,
                     input bit sw, input string tag);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_rd = rd; bus_widx = 7'(widx); bus_wdata = wd;
    pix_valid = pv; pix_idx = 8'(pidx); swap_rb = sw;
    if (sel && rd) begin q_rd.push_back(shadow[widx]); t_rd.push_back(tag); end
    if (pv) begin q_rgb.push_back(model_rgb(8'(pidx), sw)); t_rgb.push_back(tag); end
    if (sel && we) shadow[widx] = wd;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // monitor: pops and compares as results appear
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (rgb_valid) begin
        if (q_rgb.size() == 0) check(0, "R8 unexpected rgb_valid", 32'(rgb_out), 0);
        else begin
          automatic logic [23:0] e = q_rgb.pop_front();
          automatic string tg = t_rgb.pop_front();
          check(rgb_out === e, tg, 32'(rgb_out), 32'(e));
        end
      end
      if (bus_rvalid) begin
        if (q_rd.size() == 0) check(0, "R2 unexpected bus_rvalid", bus_rdata, 0);
        else begin
          automatic logic [31:0] e = q_rd.pop_front();
          automatic string tg = t_rd.pop_front();
          check(bus_rdata === e, tg, bus_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [23:0] held;
    for (int i = 0; i < 128; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_rvalid === 1'b0, "R1 rvalid after reset", 32'(bus_rvalid), 0);
    check(rgb_valid === 1'b0, "R1 rgb_valid after reset", 32'(rgb_valid), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 128; i++) cyc(1, 0, 1, i, 0, 0, 0, 0, "R1 word zero after reset");

    // R2: fill with distinct raw words, read back bit for bit
    for (int i = 0; i < 128; i++) cyc(1, 1, 0, i, pattern(i), 0, 0, 0, "write");
    for (int i = 0; i < 128; i++) cyc(1, 0, 1, i, 0, 0, 0, 0, "R2 raw readback");

    // R3: strobes without select leave the table untouched
    cyc(0, 1, 0, 5, 32'hDEAD_BEEF, 0, 0, 0, "R3");
    cyc(0, 1, 1, 9, 32'h1234_5678, 0, 0, 0, "R3");
    cyc(1, 0, 1, 5, 0, 0, 0, 0, "R3 unselected write ignored w5");
    cyc(1, 0, 1, 9, 0, 0, 0, 0, "R3 unselected write ignored w9");

    // R4 R5 R6: every entry, both halves, no swap
    for (int p = 0; p < 256; p++) cyc(0, 0, 0, 0, 0, 1, p, 0, "R4 R5 R6 lookup");
    // R7: every entry swapped
    for (int p = 0; p < 256; p++) cyc(0, 0, 0, 0, 0, 1, p, 1, "R7 swapped lookup");

    // R5: intensity bit ignored: entries 6 and 7 differ only in bit 15
    cyc(1, 1, 0, 3, 32'h8000_0000, 0, 0, 0, "write");
    cyc(0, 0, 0, 0, 0, 1, 6, 0, "R5 intensity clear gives black");
    cyc(0, 0, 0, 0, 0, 1, 7, 0, "R5 intensity set gives black");
    cyc(1, 1, 0, 3, 32'hFFFF_7FFF, 0, 0, 0, "write");
    cyc(0, 0, 0, 0, 0, 1, 6, 0, "R5 R6 white without intensity");
    cyc(0, 0, 0, 0, 0, 1, 7, 1, "R5 R6 white with intensity");
    idle(1);
    check(rgb_out === 24'hF8F8F8, "R5 R6 white value", 32'(rgb_out), 32'h00F8F8F8);
    // single components land in the right bytes
    cyc(1, 1, 0, 4, {16'h7C00, 16'h001F}, 0, 0, 0, "write");
    cyc(0, 0, 0, 0, 0, 1, 8, 0, "R5 pure red");
    cyc(0, 0, 0, 0, 0, 1, 9, 0, "R5 pure blue");
    cyc(0, 0, 0, 0, 0, 1, 8, 1, "R7 pure red swapped");
    idle(1);
    check(rgb_out === 24'h0000F8, "R7 red moved to low byte", 32'(rgb_out), 32'h000000F8);

    // R9: lookup collides with write of its word
    cyc(1, 1, 0, 20, 32'h0421_7FE0, 1, 41, 0, "R9 old entry on collision");
    cyc(0, 0, 0, 0, 0, 1, 41, 0, "R9 new entry after collision");
    cyc(1, 1, 0, 21, 32'h3C0F_0155, 1, 42, 1, "R9 old entry on collision swapped");
    cyc(0, 0, 0, 0, 0, 1, 42, 1, "R9 new entry after collision swapped");

    // R10: bus read collides with write of the same word
    cyc(1, 1, 1, 30, 32'hCAFE_F00D, 0, 0, 0, "R10 old word on collision");
    cyc(1, 0, 1, 30, 0, 0, 0, 0, "R10 new word after collision");

    // R11: outputs hold through idle cycles
    cyc(0, 0, 0, 0, 0, 1, 41, 0, "R11 setup lookup");
    cyc(1, 0, 1, 30, 0, 0, 0, 0, "R11 setup read");
    idle(1);
    held = rgb_out;
    cyc(1, 1, 0, 30, 32'h0, 0, 0, 0, "write");
    cyc(1, 1, 0, 20, 32'h0, 0, 0, 0, "write");
    idle(2);
    check(rgb_out === held, "R11 rgb_out held", 32'(rgb_out), 32'(held));
    check(bus_rdata === 32'hCAFE_F00D, "R11 bus_rdata held", bus_rdata, 32'hCAFE_F00D);

    idle(3);
    check(q_rgb.size() == 0, "R8 all lookups answered", 32'(q_rgb.size()), 0);
    check(q_rd.size() == 0, "R2 all reads answered", 32'(q_rd.size()), 0);
    finish_run();
  end
endmodule